// File: doc/BRIEF.md
# Serial Bus-Packet Frame Deserializer

This block takes a one-bit serial lane with a valid/ready handshake and rebuilds a parallel bus-request packet. Each packet has ten fields: channel id, opcode, param, size, source, address, data, corrupt flag, byte mask and a last flag, 123 bits in all. A bit moves only on a cycle where both handshake signals are high. When the final bit of a frame has been taken, the packet appears on a parallel valid/ready output. The serial side is then held off until the consumer accepts the packet.

The frame arrives in reversed bit order. The last flag comes first, and the top bit of the channel id comes last. The block undoes this reversal by where it places each bit. It has no timeout: a frame that stops partway leaves the block waiting for the missing bits until a reset arrives.

Top module: `sertl_frame_deser`

## Requirements
- R1: A serial bit is consumed only on a rising clock edge where `in_valid` and `in_ready` are both high. Cycles with `in_valid` low do not advance the frame.
- R2: Number the accepted bits of a frame from k = 0. Bit k lands at position k of the 123-bit packed frame. The packed layout is: last at [0], mask at [8:1], corrupt at [9], data at [73:10], address at [105:74], source at [109:106], size at [113:110], param at [116:114], opcode at [119:117] and channel at [122:120].
- R3: `out_valid` rises on the cycle after the 123rd bit of a frame is accepted, and not earlier.
- R4: While `out_valid` is high, `in_ready` is low. Serial bits offered during that time change neither the presented packet nor the bit position of the next frame.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` and every field output hold steady.
- R6: After `out_valid` and `out_ready` are both high on an edge, `out_valid` is low and `in_ready` is high on the next cycle. The following frame then starts at bit 0.
- R7: A partly received frame never raises `out_valid`, however long the lane stays idle. Bits that arrive later continue the same frame.
- R8: Synchronous reset clears the bit position and `out_valid`, so `in_ready` is high after reset. Any partial frame or pending packet is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Serial bit offered |
| in_ready | output | 1 | Serial bit can be taken |
| in_bit | input | 1 | Serial data bit |
| out_valid | output | 1 | Complete packet presented |
| out_ready | input | 1 | Consumer accepts packet |
| out_chan | output | 3 | Channel id |
| out_opcode | output | 3 | Opcode |
| out_param | output | 3 | Param |
| out_size | output | 4 | Transfer size |
| out_source | output | 4 | Source id |
| out_address | output | 32 | Address |
| out_data | output | 64 | Data |
| out_corrupt | output | 1 | Corrupt flag |
| out_mask | output | 8 | Byte mask |
| out_last | output | 1 | Last flag |

## Verification
The bench uses distinct field patterns to catch any shift of the bit order or of a field boundary, which would show up as wrong field values. It checks `out_valid` both one bit before the end of a frame and at the end, so an off-by-one counter, which raises valid early or late, is caught. Bits are offered while a packet is pending, and the next frame is checked bit for bit, which exposes a design that consumes input it should block. Long idle gaps mid-frame and a reset in the middle of a frame expose a spurious timeout and a counter that survives reset.

// File: rtl/sertl_pkg.sv
package sertl_pkg;
   // Default field widths of the packet
   localparam int unsigned DEF_W_CHAN    = 3;
   localparam int unsigned DEF_W_OPCODE  = 3;
   localparam int unsigned DEF_W_PARAM   = 3;
   localparam int unsigned DEF_W_SIZE    = 4;
   localparam int unsigned DEF_W_SOURCE  = 4;
   localparam int unsigned DEF_W_ADDR    = 32;
   localparam int unsigned DEF_W_DATA    = 64;
   localparam int unsigned DEF_W_CORRUPT = 1;
   localparam int unsigned DEF_W_MASK    = 8;
   localparam int unsigned DEF_W_LAST    = 1;
endpackage

// File: rtl/sertl_bit_counter.sv
module sertl_bit_counter #(
   parameter int unsigned FRAME_LEN = 123,
   parameter int unsigned CNT_W     = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

   if (FRAME_LEN < 2) begin : g_len_chk
      $error("sertl_bit_counter: FRAME_LEN must be at least 2");
   end
   if (FRAME_LEN > (1 << CNT_W)) begin : g_cnt_chk
      $error("sertl_bit_counter: CNT_W too narrow for FRAME_LEN");
   end

   assign wrap = step && (cnt == LAST_POS);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (wrap) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sertl_shift_reg.sv
module sertl_shift_reg #(
   parameter int unsigned LEN          = 123,
   parameter bit          UNDO_REVERSE = 1'b1
) (
   input  logic           clk,
   input  logic           shift,
   input  logic           din,
   output logic [LEN-1:0] q
);
   if (LEN < 2) begin : g_len_chk
      $error("sertl_shift_reg: LEN must be at least 2");
   end

   if (UNDO_REVERSE) begin : g_msb_in
      // first bit received drifts down to position 0
      always_ff @(posedge clk) begin
         if (shift) q <= {din, q[LEN-1:1]};
      end
   end else begin : g_lsb_in
      // first bit received drifts up to the top position
      always_ff @(posedge clk) begin
         if (shift) q <= {q[LEN-2:0], din};
      end
   end
endmodule

// File: rtl/sertl_hold_ctrl.sv
module sertl_hold_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic frame_done,
   input  logic out_ready,
   output logic out_valid,
   output logic in_ready
);
   assign in_ready = !out_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
      end else if (frame_done) begin
         out_valid <= 1'b1;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/sertl_frame_deser.sv
module sertl_frame_deser #(
   parameter int unsigned W_CHAN    = sertl_pkg::DEF_W_CHAN,
   parameter int unsigned W_OPCODE  = sertl_pkg::DEF_W_OPCODE,
   parameter int unsigned W_PARAM   = sertl_pkg::DEF_W_PARAM,
   parameter int unsigned W_SIZE    = sertl_pkg::DEF_W_SIZE,
   parameter int unsigned W_SOURCE  = sertl_pkg::DEF_W_SOURCE,
   parameter int unsigned W_ADDR    = sertl_pkg::DEF_W_ADDR,
   parameter int unsigned W_DATA    = sertl_pkg::DEF_W_DATA,
   parameter int unsigned W_CORRUPT = sertl_pkg::DEF_W_CORRUPT,
   parameter int unsigned W_MASK    = sertl_pkg::DEF_W_MASK,
   parameter int unsigned W_LAST    = sertl_pkg::DEF_W_LAST,
   parameter bit          UNDO_REVERSE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic                 in_bit,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [W_CHAN-1:0]    out_chan,
   output logic [W_OPCODE-1:0]  out_opcode,
   output logic [W_PARAM-1:0]   out_param,
   output logic [W_SIZE-1:0]    out_size,
   output logic [W_SOURCE-1:0]  out_source,
   output logic [W_ADDR-1:0]    out_address,
   output logic [W_DATA-1:0]    out_data,
   output logic [W_CORRUPT-1:0] out_corrupt,
   output logic [W_MASK-1:0]    out_mask,
   output logic [W_LAST-1:0]    out_last
);
   // Field offsets inside the packed frame, last flag at the bottom
   localparam int unsigned OFS_LAST    = 0;
   localparam int unsigned OFS_MASK    = OFS_LAST    + W_LAST;
   localparam int unsigned OFS_CORRUPT = OFS_MASK    + W_MASK;
   localparam int unsigned OFS_DATA    = OFS_CORRUPT + W_CORRUPT;
   localparam int unsigned OFS_ADDR    = OFS_DATA    + W_DATA;
   localparam int unsigned OFS_SOURCE  = OFS_ADDR    + W_ADDR;
   localparam int unsigned OFS_SIZE    = OFS_SOURCE  + W_SOURCE;
   localparam int unsigned OFS_PARAM   = OFS_SIZE    + W_SIZE;
   localparam int unsigned OFS_OPCODE  = OFS_PARAM   + W_PARAM;
   localparam int unsigned OFS_CHAN    = OFS_OPCODE  + W_OPCODE;
   localparam int unsigned FRAME_LEN   = OFS_CHAN    + W_CHAN;
   localparam int unsigned CNT_W       = $clog2(FRAME_LEN);

   if (W_CHAN == 0 || W_OPCODE == 0 || W_PARAM == 0 || W_SIZE == 0 ||
       W_SOURCE == 0 || W_ADDR == 0 || W_DATA == 0 || W_CORRUPT == 0 ||
       W_MASK == 0 || W_LAST == 0) begin : g_width_chk
      $error("sertl_frame_deser: every field width must be non-zero");
   end

   logic                 bit_fire;
   logic                 frame_done;
   logic [CNT_W-1:0]     bit_cnt;
   logic [FRAME_LEN-1:0] frame_q;

   assign bit_fire = in_valid && in_ready;

   sertl_bit_counter #(
      .FRAME_LEN (FRAME_LEN),
      .CNT_W     (CNT_W)
   ) i_counter (
      .clk  (clk),
      .rst  (rst),
      .step (bit_fire),
      .cnt  (bit_cnt),
      .wrap (frame_done)
   );

   sertl_shift_reg #(
      .LEN          (FRAME_LEN),
      .UNDO_REVERSE (UNDO_REVERSE)
   ) i_shift (
      .clk   (clk),
      .shift (bit_fire),
      .din   (in_bit),
      .q     (frame_q)
   );

   sertl_hold_ctrl i_hold (
      .clk        (clk),
      .rst        (rst),
      .frame_done (frame_done),
      .out_ready  (out_ready),
      .out_valid  (out_valid),
      .in_ready   (in_ready)
   );

   assign out_last    = frame_q[OFS_LAST    +: W_LAST];
   assign out_mask    = frame_q[OFS_MASK    +: W_MASK];
   assign out_corrupt = frame_q[OFS_CORRUPT +: W_CORRUPT];
   assign out_data    = frame_q[OFS_DATA    +: W_DATA];
   assign out_address = frame_q[OFS_ADDR    +: W_ADDR];
   assign out_source  = frame_q[OFS_SOURCE  +: W_SOURCE];
   assign out_size    = frame_q[OFS_SIZE    +: W_SIZE];
   assign out_param   = frame_q[OFS_PARAM   +: W_PARAM];
   assign out_opcode  = frame_q[OFS_OPCODE  +: W_OPCODE];
   assign out_chan    = frame_q[OFS_CHAN    +: W_CHAN];
endmodule

// File: rtl/sertl_frame_deser_chk.sv
module sertl_frame_deser_chk #(
   parameter int unsigned FRAME_LEN = 123,
   parameter int unsigned CNT_W     = 7
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 in_valid,
   input logic                 in_ready,
   input logic                 out_valid,
   input logic                 out_ready,
   input logic [CNT_W-1:0]     bit_cnt,
   input logic [FRAME_LEN-1:0] frame
);
   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      bit_cnt <= LAST_POS); // R2

   AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && in_ready) |=> $stable(bit_cnt)); // R1

   AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && bit_cnt == LAST_POS) |=> out_valid); // R3

   AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |-> $past(in_valid && in_ready && bit_cnt == LAST_POS)); // R7

   AST_BLOCK_INPUT: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !in_ready); // R4

   AST_HOLD_PACKET: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(frame))); // R5

   AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready) |=> (!out_valid && in_ready && bit_cnt == '0)); // R6
endmodule

bind sertl_frame_deser sertl_frame_deser_chk #(
   .FRAME_LEN (FRAME_LEN),
   .CNT_W     (CNT_W)
) i_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .bit_cnt   (bit_cnt),
   .frame     (frame_q)
);

// File: tb/test_sertl_frame_deser.sv
`timescale 1ns/1ps
module test_sertl_frame_deser;
   localparam int FL = 123;
   localparam int NVEC = 4;

   // stimulus frames, packed per R2 layout; expected output equals the frame
   localparam logic [FL-1:0] VEC [NVEC] = '{
      {3'd4, 3'd4, 3'd0, 4'd3, 4'd9, 32'h0001_0000, 64'h0, 1'b0, 8'h0F, 1'b1},
      {3'd7, 3'd0, 3'd5, 4'hA, 4'h5, 32'h8000_0004, 64'h0000_0000_DEAD_BEEF, 1'b1, 8'hF0, 1'b0},
      {3'd1, 3'd6, 3'd2, 4'h1, 4'hE, 32'hA5A5_5A5A, 64'h0123_4567_89AB_CDEF, 1'b0, 8'h81, 1'b1},
      {3'd2, 3'd3, 3'd7, 4'hF, 4'h0, 32'hFFFF_FFFE, 64'h8000_0000_0000_0001, 1'b1, 8'h3C, 1'b0}
   };
   // idle cycles inserted after each bit (R1 gaps)
   localparam int GAP [NVEC] = '{0, 1, 3, 0};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_bit = 1'b0;
   logic        out_ready = 1'b0;
   logic        in_ready, out_valid;
   logic [2:0]  out_chan, out_opcode, out_param;
   logic [3:0]  out_size, out_source;
   logic [31:0] out_address;
   logic [63:0] out_data;
   logic [0:0]  out_corrupt, out_last;
   logic [7:0]  out_mask;

   int n_checks = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   sertl_frame_deser i_sertl_frame_deser (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
      .out_chan(out_chan), .out_opcode(out_opcode), .out_param(out_param),
      .out_size(out_size), .out_source(out_source), .out_address(out_address),
      .out_data(out_data), .out_corrupt(out_corrupt), .out_mask(out_mask),
      .out_last(out_last)
   );

   function automatic logic [FL-1:0] packet();
      return {out_chan, out_opcode, out_param, out_size, out_source,
              out_address, out_data, out_corrupt, out_mask, out_last};
   endfunction

   task automatic check(input string req, input logic [FL-1:0] act, input logic [FL-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic send_bits(input logic [FL-1:0] f, input int lo, input int hi, input int gap);
      for (int k = lo; k <= hi; k++) begin
         in_valid = 1'b1;
         in_bit = f[k];
         tick();
         in_valid = 1'b0;
         for (int g = 0; g < gap; g++) tick();
      end
   endtask

   task automatic accept();
      out_ready = 1'b1;
      tick();
      out_ready = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [FL-1:0] snap;
      repeat (3) tick();
      rst = 1'b0;
      tick();
      // R8: reset state
      check("R8 out_valid after reset", FL'(out_valid), FL'(0));
      check("R8 in_ready after reset", FL'(in_ready), FL'(1));

      // table walk: R1 R2 R3
      for (int v = 0; v < NVEC; v++) begin
         send_bits(VEC[v], 0, FL-2, GAP[v]);
         check("R3 no valid before final bit", FL'(out_valid), FL'(0));
         send_bits(VEC[v], FL-1, FL-1, 0);
         check("R3 valid after final bit", FL'(out_valid), FL'(1));
         check("R2 packet fields", packet(), VEC[v]);
         check("R2 address field", FL'(out_address), FL'(VEC[v][105:74]));
         check("R2 data field", FL'(out_data), FL'(VEC[v][73:10]));
         accept();
         check("R6 released", FL'({out_valid, in_ready}), FL'(2'b01));
      end

      // R5 hold and R4 ignored input while pending
      send_bits(VEC[0], 0, FL-1, 0);
      snap = packet();
      in_valid = 1'b1;
      for (int i = 0; i < 10; i++) begin
         in_bit = i[0];
         tick();
      end
      in_valid = 1'b0;
      check("R4 in_ready low while pending", FL'(in_ready), FL'(0));
      check("R5 valid held", FL'(out_valid), FL'(1));
      check("R5 packet held", packet(), snap);
      accept();
      check("R6 released after hold", FL'({out_valid, in_ready}), FL'(2'b01));
      send_bits(VEC[2], 0, FL-1, 0);
      check("R4 next frame unaffected by blocked bits", packet(), VEC[2]);
      accept();

      // R7 partial frame waits indefinitely, then resumes
      send_bits(VEC[3], 0, 49, 0);
      repeat (400) tick();
      check("R7 no valid on stalled frame", FL'(out_valid), FL'(0));
      send_bits(VEC[3], 50, FL-1, 0);
      check("R7 resumed frame completes", FL'(out_valid), FL'(1));
      check("R7 resumed frame content", packet(), VEC[3]);
      accept();

      // R8 reset mid-frame discards the partial frame
      send_bits(VEC[1], 0, 29, 0);
      rst = 1'b1;
      tick();
      rst = 1'b0;
      check("R8 in_ready after mid-frame reset", FL'(in_ready), FL'(1));
      send_bits(VEC[1], 0, FL-2, 0);
      check("R8 counter restarted", FL'(out_valid), FL'(0));
      send_bits(VEC[1], FL-1, FL-1, 0);
      check("R8 frame after reset", packet(), VEC[1]);

      // R8 reset drops a pending packet
      rst = 1'b1;
      tick();
      rst = 1'b0;
      check("R8 pending packet dropped", FL'({out_valid, in_ready}), FL'(2'b01));

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule